// File: doc/BRIEF.md
# Link Packet Transaction Assembler

This block sits above a link layer that delivers one fixed-size DWORD per valid cycle. Each DWORD arrives with a start marker, an end marker, a type field and an error flag. The block groups these packets into transactions. The packet that carries the start marker gives the transaction its type, and its payload is taken as the address. The packets that follow are data beats, and their number varies from one transaction to the next. One cycle after the packet that closes a transaction, the block gives its verdict as a single pulse: commit or abort.

Traffic that arrives while no transaction is open is dropped without any trace on the outputs. An error flag on any packet of an open transaction poisons it, so the transaction ends in an abort. A transaction that runs to the maximum packet count without an end marker is cut off and aborted. A start marker that arrives inside an open transaction aborts that transaction. It does not open a new one.

Top module: `link_txn_assembler`

## Requirements
- R1: While reset is held, and in the first cycle after it, `hdr_valid`, `beat_valid`, `txn_commit` and `txn_abort` are all 0 and no transaction is open.
- R2: When a packet with `pkt_sop`=1 arrives while idle, `hdr_valid` pulses in the next cycle, with `hdr_addr` equal to that packet's data and `hdr_type` equal to its type.
- R3: Every packet without a start marker that arrives while a transaction is open produces `beat_valid`=1 in the next cycle, with `beat_data` equal to that packet's data.
- R4: The cycle after a packet with `pkt_eop`=1 that closes a transaction, exactly one of `txn_commit` or `txn_abort` is 1. Both are single-cycle pulses and never high together.
- R5: If any packet of a transaction, its end packet included, has `pkt_err`=1, that transaction resolves with `txn_abort` and never with `txn_commit`.
- R6: A packet with `pkt_sop`=0 that arrives while no transaction is open changes no output in the next cycle.
- R7: A packet with both `pkt_sop`=1 and `pkt_eop`=1 while idle is a complete transaction. The next cycle shows its header and its commit or abort together, and the block stays idle.
- R8: A packet with `pkt_sop`=1 inside an open transaction produces `txn_abort` in the next cycle, emits no header and no beat, and leaves the block idle.
- R9: A transaction may hold at most MAX_PKTS packets (default 16). If packet number MAX_PKTS carries no end marker, the next cycle shows that beat together with `txn_abort`, and the block returns to idle.
- R10: `txn_commit` and `txn_abort` appear only in the cycle after an end packet, an in-transaction start (R8) or a length overrun (R9), and never while an open transaction is only receiving beats or idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet is present this cycle |
| pkt_data | input | DATA_W | Packet DWORD payload |
| pkt_sop | input | 1 | Start-of-transaction marker |
| pkt_eop | input | 1 | End-of-transaction marker |
| pkt_type | input | TYPE_W | Transaction type, used on start packets |
| pkt_err | input | 1 | Data error detected on this packet |
| hdr_valid | output | 1 | Header pulse for a newly opened transaction |
| hdr_addr | output | DATA_W | Address taken from the start packet |
| hdr_type | output | TYPE_W | Type taken from the start packet |
| beat_valid | output | 1 | Data beat pulse |
| beat_data | output | DATA_W | Data beat payload |
| txn_commit | output | 1 | Transaction completed cleanly |
| txn_abort | output | 1 | Transaction discarded |

## Verification
The assertions sample the markers and the error flag only in cycles where `pkt_valid` is high. They take the inputs to be free of unknown values, but they place no ordering rule on the traffic. Any mix of starts, ends, errors and garbage is legal input, and it must be resolved as R1–R10 describe. The stimulus therefore stays within these assumptions by driving only known values. It mixes directed sequences with a long random stream that has a high rate of stray markers, including random values on the marker pins during invalid cycles.

// File: rtl/link_txn_assembler.sv
module link_txn_assembler #(
  parameter int DATA_W   = 32,
  parameter int TYPE_W   = 4,
  parameter int MAX_PKTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [DATA_W-1:0] pkt_data,
  input  logic              pkt_sop,
  input  logic              pkt_eop,
  input  logic [TYPE_W-1:0] pkt_type,
  input  logic              pkt_err,
  output logic              hdr_valid,
  output logic [DATA_W-1:0] hdr_addr,
  output logic [TYPE_W-1:0] hdr_type,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic              txn_commit,
  output logic              txn_abort
);

  localparam int CNT_W = $clog2(MAX_PKTS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_PKTS - 1);

  logic             open_q;
  logic             poison_q;
  logic [CNT_W-1:0] cnt_q;

  wire idle_start = pkt_valid && !open_q && pkt_sop;
  wire mid_start  = pkt_valid && open_q && pkt_sop;
  wire data_pkt   = pkt_valid && open_q && !pkt_sop;
  wire bad_now    = poison_q || pkt_err;
  wire at_limit   = (cnt_q == LAST_CNT);
  wire closing    = data_pkt && (pkt_eop || at_limit);
  wire clean_end  = pkt_eop && !bad_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      poison_q   <= 1'b0;
      cnt_q      <= '0;
      hdr_valid  <= 1'b0;
      hdr_addr   <= '0;
      hdr_type   <= '0;
      beat_valid <= 1'b0;
      beat_data  <= '0;
      txn_commit <= 1'b0;
      txn_abort  <= 1'b0;
    end else begin
      hdr_valid  <= idle_start;
      beat_valid <= data_pkt;
      txn_commit <= (idle_start && pkt_eop && !pkt_err) || (closing && clean_end);
      txn_abort  <= (idle_start && pkt_eop && pkt_err) || mid_start || (closing && !clean_end);
      if (idle_start) begin
        hdr_addr <= pkt_data;
        hdr_type <= pkt_type;
        open_q   <= !pkt_eop;
        poison_q <= pkt_err;
        cnt_q    <= CNT_W'(1);
      end
      if (mid_start) open_q <= 1'b0;
      if (data_pkt) begin
        beat_data <= pkt_data;
        poison_q  <= bad_now;
        cnt_q     <= cnt_q + CNT_W'(1);
        if (closing) open_q <= 1'b0;
      end
    end
  end

  assert_verdict_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_commit && txn_abort));

  assert_end_resolves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_eop && (open_q || pkt_sop)) |=> (txn_commit || txn_abort));

  assert_error_never_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_err && pkt_eop && (open_q || pkt_sop)) |=> !txn_commit);

  assert_garbage_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !open_q && !pkt_sop) |=> !(hdr_valid || beat_valid || txn_commit || txn_abort));

  assert_restart_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && open_q && pkt_sop) |=> (txn_abort && !hdr_valid && !beat_valid));

  assert_overrun_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && open_q && !pkt_sop && !pkt_eop && cnt_q == LAST_CNT) |=> (txn_abort && beat_valid));

  assert_no_spurious_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_commit || txn_abort) |-> $past(pkt_valid));

  assert_quiet_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && pkt_valid && !pkt_sop && !pkt_eop && cnt_q < LAST_CNT) |=> !(txn_commit || txn_abort));

endmodule

// File: tb/link_txn_assembler_bench.sv
module link_txn_assembler_bench;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int MAXP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0, pkt_sop = 1'b0, pkt_eop = 1'b0, pkt_err = 1'b0;
  logic [DW-1:0] pkt_data = '0;
  logic [TW-1:0] pkt_type = '0;
  logic hdr_valid, beat_valid, txn_commit, txn_abort;
  logic [DW-1:0] hdr_addr, beat_data;
  logic [TW-1:0] hdr_type;

  always #4 clk = ~clk;

  link_txn_assembler #(.DATA_W(DW), .TYPE_W(TW), .MAX_PKTS(MAXP)) u_link_txn_assembler (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_type(pkt_type), .pkt_err(pkt_err),
    .hdr_valid(hdr_valid), .hdr_addr(hdr_addr), .hdr_type(hdr_type),
    .beat_valid(beat_valid), .beat_data(beat_data),
    .txn_commit(txn_commit), .txn_abort(txn_abort));

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  bit m_open = 0, m_bad = 0;
  int m_cnt = 0;
  bit e_hdr = 0, e_beat = 0, e_com = 0, e_abt = 0;
  logic [DW-1:0] e_addr = '0, e_data = '0;
  logic [TW-1:0] e_typ = '0;

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(tag, "hdr_valid (R2)", DW'(hdr_valid), DW'(e_hdr));
    chk(tag, "beat_valid (R3/R6)", DW'(beat_valid), DW'(e_beat));
    chk(tag, "txn_commit (R4)", DW'(txn_commit), DW'(e_com));
    chk(tag, "txn_abort (R5)", DW'(txn_abort), DW'(e_abt));
    if (e_hdr) begin
      chk(tag, "hdr_addr (R2)", hdr_addr, e_addr);
      chk(tag, "hdr_type (R2)", DW'(hdr_type), DW'(e_typ));
    end
    if (e_beat) chk(tag, "beat_data (R3)", beat_data, e_data);
  endtask

  task automatic model(bit v, bit s, bit e, logic [TW-1:0] t, bit r, logic [DW-1:0] d);
    e_hdr = 0; e_beat = 0; e_com = 0; e_abt = 0;
    if (!v) return;
    if (!m_open) begin
      if (s) begin
        e_hdr = 1; e_addr = d; e_typ = t;
        if (e) begin e_com = !r; e_abt = r; end
        else begin m_open = 1; m_cnt = 1; m_bad = r; end
      end
    end else if (s) begin
      e_abt = 1; m_open = 0;
    end else begin
      e_beat = 1; e_data = d; m_bad = m_bad | r; m_cnt++;
      if (e) begin e_com = !m_bad; e_abt = m_bad; m_open = 0; end
      else if (m_cnt == MAXP) begin e_abt = 1; m_open = 0; end
    end
  endtask

  task automatic step(bit v, bit s, bit e, logic [TW-1:0] t, bit r, logic [DW-1:0] d);
    compare();
    model(v, s, e, t, r, d);
    pkt_valid = v; pkt_sop = s; pkt_eop = e; pkt_type = t; pkt_err = r; pkt_data = d;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, '0);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    idle(1);

    tag = "R6";
    step(1, 0, 0, 4'h3, 0, 32'hdead0001);
    step(1, 0, 1, 4'h3, 0, 32'hdead0002);
    step(1, 0, 1, 4'h1, 1, 32'hdead0003);
    idle(1);

    tag = "R7";
    step(1, 1, 1, 4'h5, 0, 32'h0000a000);
    step(1, 1, 1, 4'h6, 1, 32'h0000a004);
    step(1, 0, 1, 4'h0, 0, 32'h12345678);
    idle(1);

    tag = "R2";
    step(1, 1, 0, 4'h9, 0, 32'h1000_0040);
    tag = "R3";
    step(1, 0, 0, 4'h0, 0, 32'h11111111);
    step(0, 0, 0, 4'h0, 0, 32'h0);
    tag = "R10";
    idle(3);
    step(1, 0, 0, 4'h0, 0, 32'h22222222);
    tag = "R4";
    step(1, 0, 1, 4'h0, 0, 32'h33333333);
    idle(2);

    tag = "R5";
    step(1, 1, 0, 4'h2, 0, 32'h2000_0000);
    step(1, 0, 0, 4'h0, 1, 32'haaaa0001);
    step(1, 0, 0, 4'h0, 0, 32'haaaa0002);
    step(1, 0, 1, 4'h0, 0, 32'haaaa0003);
    step(1, 1, 0, 4'h2, 0, 32'h2000_0100);
    step(1, 0, 1, 4'h0, 1, 32'hbbbb0001);
    step(1, 1, 0, 4'h2, 1, 32'h2000_0200);
    step(1, 0, 1, 4'h0, 0, 32'hbbbb0002);
    idle(1);

    tag = "R8";
    step(1, 1, 0, 4'h7, 0, 32'h3000_0000);
    step(1, 0, 0, 4'h0, 0, 32'hcccc0001);
    step(1, 1, 0, 4'h8, 0, 32'h3000_0100);
    step(1, 0, 0, 4'h0, 0, 32'hcccc0002);
    step(1, 0, 1, 4'h0, 0, 32'hcccc0003);
    idle(1);

    tag = "R9";
    step(1, 1, 0, 4'ha, 0, 32'h4000_0000);
    for (int i = 1; i < MAXP; i++) step(1, 0, 0, 4'h0, 0, 32'(i));
    step(1, 0, 1, 4'h0, 0, 32'hffff0000);
    step(1, 1, 0, 4'hb, 0, 32'h5000_0000);
    for (int i = 1; i < MAXP - 1; i++) step(1, 0, 0, 4'h0, 0, 32'(i + 100));
    step(1, 0, 1, 4'h0, 0, 32'h5555aaaa);
    idle(2);

    tag = "random";
    for (int n = 0; n < 6000; n++) begin
      int p = $urandom_range(99);
      bit v = p < 75;
      bit s = ($urandom_range(99) < 12);
      bit e = ($urandom_range(99) < 15);
      bit r = ($urandom_range(99) < 6);
      step(v, s, e, TW'($urandom), r, $urandom);
    end
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule